// File: doc/BRIEF.md
# Register Window Pointer Controller

This block keeps the current window pointer for a windowed integer register file that holds `NWINDOWS` overlapping windows, where `NWINDOWS` is a power of two. A call-side request (save) moves the pointer down by one window. A return-side request (restore) moves it up by one window. Both wrap modulo the window count. Before it moves, the controller looks up the destination window in a per-window invalid mask. If that bit is set, the pointer stays where it is and the block emits a one-cycle trap pulse with a cause code instead. Save requests report a spill cause and restore requests report a fill cause.

The block also turns a 5-bit architectural register number into a physical register-file address. Registers 0 to 7 are shared by every window. Registers 8 to 31 fall in the current window, and the top eight of them alias the low eight of the window above. A single-word control port loads either the invalid mask or the pointer directly.

Top module: `rwin_ctrl`

## Requirements
- R1: A save request, when the mask bit of window (pointer - 1) mod NWINDOWS is clear, sets the pointer to that window on the next clock edge.
- R2: A restore request, when the mask bit of window (pointer + 1) mod NWINDOWS is clear, sets the pointer to that window on the next clock edge.
- R3: When the mask bit of the destination window is set, the pointer does not change. After the next edge `trap_valid` is 1 and `trap_cause` is 2'b01 for a save or 2'b10 for a restore.
- R4: `trap_valid` is a pulse one cycle long per trapping request, and `trap_cause` is 2'b00 whenever `trap_valid` is 0.
- R5: Architectural indices 0 to 7 map to physical addresses 0 to 7 whatever the pointer is.
- R6: An index i from 8 to 31 maps to 8 + ((pointer*16 + i - 8) mod (NWINDOWS*16)), so indices 24 to 31 of window w give the same addresses as indices 8 to 15 of window (w+1) mod NWINDOWS.
- R7: A control write with `ctl_sel`=0 loads the mask from the low NWINDOWS bits of `ctl_wdata`. With `ctl_sel`=1 it loads the pointer from the low log2(NWINDOWS) bits. A save or restore in the same cycle is ignored.
- R8: A save and a restore asserted together, with no control write, are ignored: the pointer holds and no trap is raised.
- R9: Reset (synchronous, active-low) sets the pointer to 0, clears the mask and clears the trap outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| save_req | input | 1 | Move one window down |
| restore_req | input | 1 | Move one window up |
| ctl_we | input | 1 | Control write strobe |
| ctl_sel | input | 1 | Control target: 0 mask, 1 pointer |
| ctl_wdata | input | CTL_W | Control write data |
| arch_idx | input | 5 | Architectural register number |
| phys_addr | output | log2(NWINDOWS)+5 | Physical register-file address |
| cwp | output | log2(NWINDOWS) | Current window pointer |
| wim | output | NWINDOWS | Window invalid mask |
| trap_valid | output | 1 | Trap pulse |
| trap_cause | output | 2 | 01 spill, 10 fill, 00 none |

## Verification
The bench drives the pointer across both wrap points (0 to top on a save, top to 0 on a restore). A design that masks with the wrong width or increments in the wrong direction lands on the wrong window there. It places a mask bit just below and just above the pointer, so that a design checking the current window instead of the destination traps at the wrong time or moves when it should freeze. It sweeps all 32 indices at every pointer value, including the top window, whose upper eight registers must wrap onto window 0. It also hits a save together with a restore and a control write together with a request, where a design with the wrong priority would move the pointer or raise a trap.

// File: rtl/rwin_pkg.sv
package rwin_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'b00,
        CAUSE_SPILL = 2'b01,
        CAUSE_FILL  = 2'b10
    } trap_cause_e;

    // control port target select
    localparam logic SEL_MASK = 1'b0;
    localparam logic SEL_PTR  = 1'b1;

    // architectural register grouping
    localparam int SHARED_REGS = 8;
    localparam int WIN_STRIDE  = 16;
    localparam int IDX_W       = 5;

endpackage

// File: rtl/rwin_step.sv
module rwin_step
    import rwin_pkg::*;
#(
    parameter int NWINDOWS = 8,
    localparam int CW = $clog2(NWINDOWS)
) (
    input  logic [CW-1:0]       cur_ptr,
    input  logic [NWINDOWS-1:0] inv_mask,
    input  logic                down_req,
    input  logic                up_req,
    output logic                move_en,
    output logic [CW-1:0]       next_ptr,
    output logic                trap_en,
    output trap_cause_e         trap_code
);

    logic                req_one;
    logic [CW-1:0]       target;
    logic [NWINDOWS-1:0] hit;

    // a lone request only; both together cancel
    assign req_one = down_req ^ up_req;

    // power-of-two window count: natural wrap of the CW-bit sum
    assign target = down_req ? (cur_ptr - CW'(1)) : (cur_ptr + CW'(1));

    // per-window decode of the destination against the invalid mask
    for (genvar g = 0; g < NWINDOWS; g++) begin : g_hit
        assign hit[g] = (target == CW'(g)) && inv_mask[g];
    end

    always_comb begin
        trap_en   = req_one && (|hit);
        move_en   = req_one && !(|hit);
        next_ptr  = target;
        trap_code = CAUSE_NONE;
        if (trap_en) begin
            trap_code = down_req ? CAUSE_SPILL : CAUSE_FILL;
        end
    end

endmodule

// File: rtl/rwin_addr_map.sv
module rwin_addr_map
    import rwin_pkg::*;
#(
    parameter int NWINDOWS = 8,
    localparam int CW   = $clog2(NWINDOWS),
    localparam int PA_W = CW + 5
) (
    input  logic [CW-1:0]    cur_ptr,
    input  logic [IDX_W-1:0] idx,
    output logic [PA_W-1:0]  addr
);

    logic            shared;
    logic [IDX_W-1:0] offset;
    logic [CW+4:0]   sum;
    logic [CW+3:0]   ring;

    assign shared = (idx < IDX_W'(SHARED_REGS));
    assign offset = idx - IDX_W'(SHARED_REGS);

    // window base is pointer*16; the windowed ring is NWINDOWS*16 deep,
    // so dropping the top bit of the sum is the modulo
    assign sum  = {1'b0, cur_ptr, 4'b0000} + {{CW{1'b0}}, offset};
    assign ring = sum[CW+3:0];

    always_comb begin
        if (shared) begin
            addr = {{(PA_W-IDX_W){1'b0}}, idx};
        end else begin
            addr = {1'b0, ring} + PA_W'(SHARED_REGS);
        end
    end

endmodule

// File: rtl/rwin_ctrl.sv
module rwin_ctrl
    import rwin_pkg::*;
#(
    parameter int NWINDOWS = 8,
    parameter int CTL_W    = 32,
    localparam int CW   = $clog2(NWINDOWS),
    localparam int PA_W = CW + 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                save_req,
    input  logic                restore_req,
    input  logic                ctl_we,
    input  logic                ctl_sel,
    input  logic [CTL_W-1:0]    ctl_wdata,
    input  logic [4:0]          arch_idx,
    output logic [PA_W-1:0]     phys_addr,
    output logic [CW-1:0]       cwp,
    output logic [NWINDOWS-1:0] wim,
    output logic                trap_valid,
    output logic [1:0]          trap_cause
);

    typedef struct packed {
        logic [CW-1:0]       ptr;
        logic [NWINDOWS-1:0] mask;
        logic                tv;
        trap_cause_e         cause;
    } state_t;

    state_t st_d, st_q;

    logic        step_move;
    logic        step_trap;
    logic [CW-1:0] step_next;
    trap_cause_e step_cause;

    rwin_step #(.NWINDOWS(NWINDOWS)) u_step (
        .cur_ptr   (st_q.ptr),
        .inv_mask  (st_q.mask),
        .down_req  (save_req),
        .up_req    (restore_req),
        .move_en   (step_move),
        .next_ptr  (step_next),
        .trap_en   (step_trap),
        .trap_code (step_cause)
    );

    rwin_addr_map #(.NWINDOWS(NWINDOWS)) u_map (
        .cur_ptr (st_q.ptr),
        .idx     (arch_idx),
        .addr    (phys_addr)
    );

    always_comb begin
        st_d       = st_q;
        st_d.tv    = 1'b0;
        st_d.cause = CAUSE_NONE;
        if (ctl_we) begin
            if (ctl_sel == SEL_PTR) begin
                st_d.ptr = ctl_wdata[CW-1:0];
            end else begin
                st_d.mask = ctl_wdata[NWINDOWS-1:0];
            end
        end else if (step_trap) begin
            st_d.tv    = 1'b1;
            st_d.cause = step_cause;
        end else if (step_move) begin
            st_d.ptr = step_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{ptr: '0, mask: '0, tv: 1'b0, cause: CAUSE_NONE};
        end else begin
            st_q <= st_d;
        end
    end

    assign cwp        = st_q.ptr;
    assign wim        = st_q.mask;
    assign trap_valid = st_q.tv;
    assign trap_cause = st_q.cause;

    // R1
    p_save_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && !restore_req && !ctl_we && !wim[cwp - CW'(1)])
        |=> (cwp == $past(cwp) - CW'(1)));

    // R2
    p_restore_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_req && !save_req && !ctl_we && !wim[cwp + CW'(1)])
        |=> (cwp == $past(cwp) + CW'(1)));

    // R3
    p_trap_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> (cwp == $past(cwp)));

    // R4
    p_cause_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> (trap_cause == 2'b01 || trap_cause == 2'b10));

    // R4
    p_cause_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid |-> (trap_cause == 2'b00));

    // R5
    p_shared_map_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (arch_idx < 5'd8) |-> (phys_addr == PA_W'(arch_idx)));

    // R7
    p_ctl_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_sel == SEL_MASK) |=> (wim == $past(ctl_wdata[NWINDOWS-1:0])));

    // R8
    p_conflict_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && restore_req && !ctl_we) |=> (!trap_valid && $stable(cwp)));

endmodule

// File: tb/tb_rwin_ctrl.sv
`timescale 1ns/1ps
module tb_rwin_ctrl;

    localparam int NW   = 8;
    localparam int CW   = $clog2(NW);
    localparam int PA_W = CW + 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            save_req = 1'b0;
    logic            restore_req = 1'b0;
    logic            ctl_we = 1'b0;
    logic            ctl_sel = 1'b0;
    logic [31:0]     ctl_wdata = '0;
    logic [4:0]      arch_idx = '0;
    logic [PA_W-1:0] phys_addr;
    logic [CW-1:0]   cwp;
    logic [NW-1:0]   wim;
    logic            trap_valid;
    logic [1:0]      trap_cause;

    rwin_ctrl #(.NWINDOWS(NW), .CTL_W(32)) dut (
        .clk(clk), .rst_n(rst_n), .save_req(save_req), .restore_req(restore_req),
        .ctl_we(ctl_we), .ctl_sel(ctl_sel), .ctl_wdata(ctl_wdata), .arch_idx(arch_idx),
        .phys_addr(phys_addr), .cwp(cwp), .wim(wim),
        .trap_valid(trap_valid), .trap_cause(trap_cause)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit armed = 0;
    bit done = 0;

    // behavioural reference
    int    m_ptr = 0;
    int    m_mask = 0;
    int    m_tv = 0;
    int    m_cause = 0;
    string m_tag = "R9";

    always @(posedge clk) begin
        armed = 1;
        m_tv = 0;
        m_cause = 0;
        if (!rst_n) begin
            m_ptr = 0; m_mask = 0; m_tag = "R9";
        end else if (ctl_we) begin
            m_tag = "R7";
            if (ctl_sel) m_ptr = ctl_wdata % NW;
            else m_mask = ctl_wdata & ((1 << NW) - 1);
        end else if (save_req && restore_req) begin
            m_tag = "R8";
        end else if (save_req || restore_req) begin
            int t;
            t = save_req ? (m_ptr + NW - 1) % NW : (m_ptr + 1) % NW;
            if ((m_mask >> t) & 1) begin
                m_tv = 1; m_cause = save_req ? 1 : 2; m_tag = "R3";
            end else begin
                m_ptr = t; m_tag = save_req ? "R1" : "R2";
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (armed && !done) begin
            int ea;
            int i;
            i  = int'(arch_idx);
            ea = (i < 8) ? i : 8 + ((m_ptr * 16 + i - 8) % (NW * 16));
            chk(m_tag, "cwp", int'(cwp), m_ptr);
            chk((m_tag == "R9") ? "R9" : "R7", "wim", int'(wim), m_mask);
            chk("R3,R4", "trap_valid", int'(trap_valid), m_tv);
            chk("R3,R4", "trap_cause", int'(trap_cause), m_cause);
            chk((i < 8) ? "R5" : "R6", "phys_addr", int'(phys_addr), ea);
        end
    end

    task automatic drive(input bit s, input bit r, input bit we, input bit sel,
                         input int data, input int idx);
        @(posedge clk);
        #1;
        save_req = s; restore_req = r; ctl_we = we; ctl_sel = sel;
        ctl_wdata = data; arch_idx = idx[4:0];
    endtask

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            failures++;
            $display("FAIL watchdog expired at cycle %0d expected completion", cyc);
            finish_run();
        end
    end

    initial begin
        // R9: reset state
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        drive(0, 0, 0, 0, 0, 9);
        // R1: save from 0 wraps to top window
        drive(1, 0, 0, 0, 0, 31);
        drive(1, 0, 0, 0, 0, 24);
        // R2: restore back, then wrap top to 0
        drive(0, 1, 0, 0, 0, 8);
        drive(0, 1, 0, 0, 0, 3);
        drive(0, 0, 1, 1, 7, 31);
        drive(0, 1, 0, 0, 0, 15);
        // R3: invalid window just below pointer 0 (window 7): spill
        drive(0, 0, 1, 0, 32'h80, 0);
        drive(1, 0, 0, 0, 0, 0);
        // R4: back-to-back trapping saves, then idle
        drive(1, 0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0);
        // R3: invalid window above pointer: fill
        drive(0, 0, 1, 0, 32'h02, 0);
        drive(0, 1, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0);
        // R8: both requests together
        drive(1, 1, 0, 0, 0, 20);
        drive(0, 0, 0, 0, 0, 20);
        // R7: control write wins over a request; upper data bits dropped
        drive(1, 0, 1, 1, 32'hFFFF_FFF3, 20);
        drive(0, 1, 1, 0, 32'hABCD_0000, 20);
        drive(0, 0, 0, 0, 0, 20);
        // R5, R6: sweep every index at every pointer value
        for (int w = 0; w < NW; w++) begin
            drive(0, 0, 1, 1, w, 0);
            for (int i = 0; i < 32; i++) drive(0, 0, 0, 0, 0, i);
        end
        // mixed traffic
        for (int n = 0; n < 3000; n++) begin
            int k;
            k = $urandom % 20;
            if (k == 0)      drive(0, 0, 1, 0, $urandom, $urandom % 32);
            else if (k == 1) drive(0, 0, 1, 1, $urandom, $urandom % 32);
            else             drive(($urandom % 2) == 1, ($urandom % 2) == 1, 0, 0, 0, $urandom % 32);
        end
        drive(0, 0, 0, 0, 0, 0);
        @(posedge clk);
        @(negedge clk);
        #1;
        finish_run();
    end

endmodule